// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small record of why the device last came out of reset. Four event inputs report a power-on, a supply brown-out, an external reset pin and a watchdog expiry. Each non-power-on event sets its own sticky flag. The flags live in a storage domain that only the power-on signal resets, so a record survives every other kind of reset.

Software reads the record over a simple register bus. The register is decoded at an I/O-space address and at a data-space alias that is offset by a fixed amount. To clear individual flags, software writes a zero to each bit it wants cleared. The usual practice is to read and clear the register early after boot. Any later reset then leaves exactly its own cause behind.

Top module: `rst_cause_reg`

## Requirements
- R1: When the power-on input is released, the register reads 0x01. The bit positions are: bit 3 watchdog, bit 2 brown-out, bit 1 external, bit 0 power-on.
- R2: A watchdog, brown-out or external event pulse sets its own flag. All other flags keep their values.
- R3: A write clears every flag bit 3..0 whose write-data bit is 0. Any flag whose write-data bit is 1 is left unchanged.
- R4: The power-on flag (bit 0) is cleared only by a write of 0 to bit 0. No watchdog, brown-out or external event changes it.
- R5: Bits 7..4 ignore writes and always read 0.
- R6: When several non-power-on events arrive in the same cycle, all of their flags are set together.
- R7: When an event and a write of 0 to the same flag occur in one cycle, the flag ends up set.
- R8: The register responds to reads and writes at address 0x34 and at 0x54 (0x34 + 0x20). Accesses to any other address leave the flags unchanged and return 0.
- R9: Asserting power-on clears bits 3..1 and sets bit 0, whatever events are active at the same time.
- R10: On the clock edge after a read strobe to a decoded address, read data holds the flag value from before that edge. In any cycle without a read hit, read data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| porEvt | input | 1 | Power-on indication. Active high and asynchronous. It is the only reset of the flag storage. |
| borEvt | input | 1 | Brown-out reset event pulse |
| extEvt | input | 1 | External pin reset event pulse |
| wdtEvt | input | 1 | Watchdog reset event pulse |
| busAddr | input | ADDR_W (8) | Register bus address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |

## Verification
The flag logic is exercised with three kinds of event pattern: single events, which show that each flag sets in its own bit position; events arriving together, which expose any priority between sources; and events that land in the same cycle as a clearing write, which shows whether set or clear wins. Writes use mixed ones-and-zeros masks, which distinguish write-zero-to-clear from plain overwrite and from write-one-to-clear. The same accesses are repeated at both decoded addresses and at an unrelated address to confirm the address decode. Power-on is asserted while other events are active, to show that it overrides them.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int DATA_W    = 8;
  localparam int NUM_FLAGS = 4;
  // flag positions within the register (software-visible)
  localparam int IDX_POR = 0;
  localparam int IDX_EXT = 1;
  localparam int IDX_BOR = 2;
  localparam int IDX_WDT = 3;

  typedef struct packed {
    logic rdHit;
    logic wrHit;
  } rcStrobe_t;
endpackage

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] IO_ADDR   = 8'h34,
  parameter logic [ADDR_W-1:0] ALIAS_OFS = 8'h20
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output rcStrobe_t         strobe
);
  localparam int NUM_MAP = 2;
  localparam logic [ADDR_W-1:0] DATA_ADDR = IO_ADDR + ALIAS_OFS;

  logic [NUM_MAP-1:0] mapHit;

  for (genvar m = 0; m < NUM_MAP; m++) begin : g_map
    localparam logic [ADDR_W-1:0] BASE = (m == 0) ? IO_ADDR : DATA_ADDR;
    assign mapHit[m] = (busAddr == BASE);
  end

  always_comb begin
    strobe.rdHit = busRd && (|mapHit);
    strobe.wrHit = busWr && (|mapHit);
  end
endmodule

// File: rtl/rst_cause_dp.sv
module rst_cause_dp
  import rst_cause_pkg::*;
(
  input  logic                 clk,
  input  logic                 porEvt,
  input  rcStrobe_t            strobe,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [NUM_FLAGS-1:0] evtVec,
  output logic [NUM_FLAGS-1:0] flagVec,
  output logic [DATA_W-1:0]    busRdata
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    localparam logic POR_VAL = 1'(i == IDX_POR);
    logic flagQ;
    logic clrReq;

    assign clrReq = strobe.wrHit && !busWdata[i];

    always_ff @(posedge clk or posedge porEvt) begin
      if (porEvt)         flagQ <= POR_VAL;
      else if (evtVec[i]) flagQ <= 1'b1;   // event beats clear
      else if (clrReq)    flagQ <= 1'b0;
    end

    assign flagVec[i] = flagQ;
  end

  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk or posedge porEvt) begin
    if (porEvt)            rdQ <= '0;
    else if (strobe.rdHit) rdQ <= DATA_W'(flagVec);
    else                   rdQ <= '0;
  end

  assign busRdata = rdQ;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] IO_ADDR   = 8'h34,
  parameter logic [ADDR_W-1:0] ALIAS_OFS = 8'h20
) (
  input  logic              clk,
  input  logic              porEvt,
  input  logic              borEvt,
  input  logic              extEvt,
  input  logic              wdtEvt,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata
);
  rcStrobe_t            strobe;
  logic [NUM_FLAGS-1:0] evtVec;
  logic [NUM_FLAGS-1:0] flagVec;

  always_comb begin
    evtVec          = '0;
    evtVec[IDX_POR] = 1'b0;  // power-on acts only through the async reset
    evtVec[IDX_EXT] = extEvt;
    evtVec[IDX_BOR] = borEvt;
    evtVec[IDX_WDT] = wdtEvt;
  end

  rst_cause_ctrl #(
    .ADDR_W   (ADDR_W),
    .IO_ADDR  (IO_ADDR),
    .ALIAS_OFS(ALIAS_OFS)
  ) u_ctrl (
    .busAddr(busAddr),
    .busRd  (busRd),
    .busWr  (busWr),
    .strobe (strobe)
  );

  rst_cause_dp u_dp (
    .clk     (clk),
    .porEvt  (porEvt),
    .strobe  (strobe),
    .busWdata(busWdata),
    .evtVec  (evtVec),
    .flagVec (flagVec),
    .busRdata(busRdata)
  );
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] IO_ADDR   = 8'h34,
  parameter logic [ADDR_W-1:0] ALIAS_OFS = 8'h20
) (
  input logic              clk,
  input logic              porEvt,
  input logic              borEvt,
  input logic              extEvt,
  input logic              wdtEvt,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [7:0]        busWdata,
  input logic [7:0]        busRdata,
  input logic [3:0]        flagVec
);
  logic addrOk;
  assign addrOk = (busAddr == IO_ADDR) || (busAddr == IO_ADDR + ALIAS_OFS);

  a_r2_wdt_sets: assert property (@(posedge clk) disable iff (porEvt)
    wdtEvt |=> flagVec[3]);
  a_r2_bor_sets: assert property (@(posedge clk) disable iff (porEvt)
    borEvt |=> flagVec[2]);
  a_r2_ext_sets: assert property (@(posedge clk) disable iff (porEvt)
    extEvt |=> flagVec[1]);
  a_r4_por_sticky: assert property (@(posedge clk) disable iff (porEvt)
    (flagVec[0] && !(busWr && addrOk && !busWdata[0])) |=> flagVec[0]);
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (porEvt)
    busRdata[7:4] == 4'h0);
  a_r6_all_set: assert property (@(posedge clk) disable iff (porEvt)
    (wdtEvt && borEvt && extEvt) |=> (flagVec[3:1] == 3'b111));
  a_r8_bad_addr: assert property (@(posedge clk) disable iff (porEvt)
    (!addrOk && !wdtEvt && !borEvt && !extEvt) |=> $stable(flagVec));
  a_r10_read_val: assert property (@(posedge clk) disable iff (porEvt)
    (busRd && addrOk) |=> (busRdata == {4'h0, $past(flagVec)}));
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (porEvt)
    !(busRd && addrOk) |=> (busRdata == 8'h00));
endmodule

bind rst_cause_reg rst_cause_chk #(
  .ADDR_W   (ADDR_W),
  .IO_ADDR  (IO_ADDR),
  .ALIAS_OFS(ALIAS_OFS)
) u_chk (
  .clk     (clk),
  .porEvt  (porEvt),
  .borEvt  (borEvt),
  .extEvt  (extEvt),
  .wdtEvt  (wdtEvt),
  .busAddr (busAddr),
  .busRd   (busRd),
  .busWr   (busWr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .flagVec (flagVec)
);

// File: tb/rst_cause_reg_test.sv
module rst_cause_reg_test;
  logic       clk = 1'b0;
  logic       porEvt = 1'b1;
  logic       borEvt = 1'b0, extEvt = 1'b0, wdtEvt = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busRd = 1'b0, busWr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  rst_cause_reg uut (
    .clk(clk), .porEvt(porEvt), .borEvt(borEvt), .extEvt(extEvt),
    .wdtEvt(wdtEvt), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  // evt = {wdt, bor, ext}; after the cycle, the register read at 0x34 must equal expv
  typedef struct packed {
    logic [2:0] evt;
    logic       wr;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] expv;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'b001, 1'b0, 8'h34, 8'h00, 8'h03},  // R2 external sets bit 1
    '{3'b000, 1'b1, 8'h34, 8'hFF, 8'h03},  // R3/R5 writing ones changes nothing
    '{3'b110, 1'b0, 8'h34, 8'h00, 8'h0F},  // R6 wdt+bor together
    '{3'b000, 1'b1, 8'h34, 8'hFE, 8'h0E},  // R4 zero to bit 0 clears power-on flag
    '{3'b000, 1'b1, 8'h34, 8'h0B, 8'h0A},  // R3 clears only bit 2
    '{3'b100, 1'b1, 8'h34, 8'h00, 8'h08},  // R7 wdt event beats clear
    '{3'b000, 1'b1, 8'h00, 8'h00, 8'h08},  // R8 foreign address ignored
    '{3'b000, 1'b1, 8'h54, 8'h00, 8'h00},  // R8 alias address clears
    '{3'b010, 1'b0, 8'h34, 8'h00, 8'h04}   // R2 bor alone, others stay
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic busCycle(input logic [2:0] evt, input logic wr,
                          input logic [7:0] addr, input logic [7:0] wdata);
    @(negedge clk);
    {wdtEvt, borEvt, extEvt} = evt;
    busWr = wr; busAddr = addr; busWdata = wdata;
    @(posedge clk);
    @(negedge clk);
    {wdtEvt, borEvt, extEvt} = 3'b000;
    busWr = 1'b0; busWdata = 8'h00;
  endtask

  task automatic readReg(input logic [7:0] addr, output logic [7:0] val);
    @(negedge clk);
    busRd = 1'b1; busAddr = addr;
    @(posedge clk);
    @(negedge clk);
    val = busRdata;
    busRd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset rdata", busRdata, 8'h00);
    porEvt = 1'b0;
    readReg(8'h34, rv);
    check("R1 post power-on", rv, 8'h01);
    @(negedge clk);
    check("R10 idle rdata zero", busRdata, 8'h00);

    for (int k = 0; k < NV; k++) begin
      busCycle(VECS[k].evt, VECS[k].wr, VECS[k].addr, VECS[k].wdata);
      readReg(8'h34, rv);
      check($sformatf("vector %0d (R2-R8 table)", k), rv, VECS[k].expv);
    end

    // R8: read at alias returns the same value; foreign address reads 0
    readReg(8'h54, rv);
    check("R8 alias read", rv, 8'h04);
    readReg(8'h35, rv);
    check("R8 foreign read zero", rv, 8'h00);

    // R5: upper bits ignore ones
    busCycle(3'b000, 1'b1, 8'h34, 8'hF4);
    readReg(8'h34, rv);
    check("R5 upper bits zero", rv, 8'h04);

    // R4: events never touch power-on flag
    busCycle(3'b111, 1'b0, 8'h34, 8'h00);
    readReg(8'h34, rv);
    check("R4 por flag untouched by events", rv, 8'h0E);

    // R10: read returns pre-edge value while an event lands in the same cycle
    busCycle(3'b000, 1'b1, 8'h34, 8'h00);
    @(negedge clk);
    busRd = 1'b1; busAddr = 8'h34; extEvt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busRd = 1'b0; extEvt = 1'b0;
    check("R10 read shows pre-edge value", busRdata, 8'h00);
    readReg(8'h34, rv);
    check("R10 next read shows new flag", rv, 8'h02);

    // R9: power-on with concurrent events
    @(negedge clk);
    porEvt = 1'b1; wdtEvt = 1'b1; borEvt = 1'b1; extEvt = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    porEvt = 1'b0; wdtEvt = 1'b0; borEvt = 1'b0; extEvt = 1'b0;
    readReg(8'h54, rv);
    check("R9 power-on overrides events", rv, 8'h01);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule